// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns a fetched instruction's operation field and function field into the steering and enable signals of a single-cycle core. It is purely combinational. The outputs settle within the same cycle that the instruction word is presented. They select the destination register field, the second ALU operand, the write-back source, the register and memory write enables, the memory read enable, the branch and jump requests, and a 4-bit ALU operation code.

Decoding happens at two levels. A first-level decoder looks only at the 6-bit opcode. It produces the enables and a 2-bit ALU class:

- 00 forces an add, used for address generation.
- 01 forces a subtract, used for the equality compare.
- 10 hands the choice to the function field.

A second-level decoder combines that class with the 6-bit function field. The core takes a branch when the branch request is set and the ALU zero flag is set.

Top module: `ctl_decoder`

## Requirements
- R1: Opcode 0 (register format) drives dst_sel_rd=1 and reg_we=1. It drives alu_b_imm=0, wb_from_mem=0, and mem_re, mem_we, br_en and jmp_en all to 0.
- R2: Opcode 35 (load word) drives alu_b_imm=1, wb_from_mem=1, reg_we=1, mem_re=1, dst_sel_rd=0 and alu_ctl=0010 (add). It drives mem_we, br_en and jmp_en to 0.
- R3: Opcode 43 (store word) drives mem_we=1, alu_b_imm=1 and alu_ctl=0010. It drives reg_we, mem_re, br_en, jmp_en, dst_sel_rd and wb_from_mem to 0.
- R4: Opcode 4 (branch if equal) drives br_en=1 and alu_ctl=0110 (subtract). All other outputs are 0.
- R5: Opcode 2 (jump) drives jmp_en=1 and alu_ctl=0010. All other outputs are 0.
- R6: For opcode 0, the low four function bits select the ALU code as follows:
  - 0000 gives 0010 (add).
  - 0010 gives 0110 (subtract).
  - 0100 gives 0000 (AND).
  - 0101 gives 0001 (OR).
  - 1010 gives 0111 (set-less-than).
  - Any other pattern gives 0010.
- R7: For opcode 0, function bits 5 and 4 have no effect on any output.
- R8: For every opcode other than 0, the function field has no effect on any output.
- R9: Any opcode other than 0, 2, 4, 35 and 43 drives every single-bit output to 0 and alu_ctl to 0010.
- R10: At most one of mem_re, mem_we, br_en and jmp_en is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Instruction bits 31..26 |
| fn_code | input | 6 | Instruction bits 5..0 |
| dst_sel_rd | output | 1 | 1: destination from bits 15..11, 0: from bits 20..16 |
| alu_b_imm | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem | output | 1 | 1: register write data comes from data memory |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| br_en | output | 1 | Conditional branch request (taken with ALU zero) |
| jmp_en | output | 1 | Unconditional jump request |
| alu_ctl | output | 4 | ALU operation code |

## Verification
The enable decode and the ALU code selection are derived from the same opcode in the same cycle. A fault in the shared first-level class signal can therefore corrupt both at once, or only one of them. Random opcode and function pairs are applied together, including function values that look like valid register-format codes under non-register opcodes. Every output bit is compared against an independent bench model in that same cycle. This exposes cases where the function field leaks into a memory or branch decode, or where the ALU class and the enables disagree.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int AC_W = 4;
  localparam int SEL_W = 4;  // function bits that carry the selection

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'd2;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OPC_STORE = 6'd43;

  localparam logic [SEL_W-1:0] FN_ADD = 4'b0000;
  localparam logic [SEL_W-1:0] FN_SUB = 4'b0010;
  localparam logic [SEL_W-1:0] FN_AND = 4'b0100;
  localparam logic [SEL_W-1:0] FN_OR  = 4'b0101;
  localparam logic [SEL_W-1:0] FN_SLT = 4'b1010;

  localparam logic [AC_W-1:0] AC_AND = 4'b0000;
  localparam logic [AC_W-1:0] AC_OR  = 4'b0001;
  localparam logic [AC_W-1:0] AC_ADD = 4'b0010;
  localparam logic [AC_W-1:0] AC_SUB = 4'b0110;
  localparam logic [AC_W-1:0] AC_SLT = 4'b0111;

  typedef enum logic [1:0] {
    AO_ADD = 2'b00,
    AO_SUB = 2'b01,
    AO_FN  = 2'b10
  } aluop_e;

  typedef struct packed {
    logic   dst_rd;
    logic   b_imm;
    logic   wb_mem;
    logic   reg_we;
    logic   mem_re;
    logic   mem_we;
    logic   br;
    logic   jmp;
    aluop_e aluop;
  } ctl_t;
endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
  import ctl_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] op_code,
  output ctl_t           ctl
);
  always_comb begin
    ctl       = '0;
    ctl.aluop = AO_ADD;
    unique case (op_code)
      OPC_RTYPE: begin
        ctl.dst_rd = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.aluop  = AO_FN;
      end
      OPC_LOAD: begin
        ctl.b_imm  = 1'b1;
        ctl.wb_mem = 1'b1;
        ctl.reg_we = 1'b1;
        ctl.mem_re = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_imm  = 1'b1;
        ctl.mem_we = 1'b1;
      end
      OPC_BEQ: begin
        ctl.br    = 1'b1;
        ctl.aluop = AO_SUB;
      end
      OPC_JMP: begin
        ctl.jmp = 1'b1;
      end
      default: begin
        ctl       = '0;
        ctl.aluop = AO_ADD;
      end
    endcase
  end
endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
  import ctl_pkg::*;
#(
  parameter int FNW = FN_W,
  parameter int ACW = AC_W
) (
  input  aluop_e         aluop,
  input  logic [FNW-1:0] fn_code,
  output logic [ACW-1:0] alu_ctl
);
  localparam int SW = SEL_W;

  logic [SW-1:0]  sel;
  logic [FNW-1:0] unused_fn;

  assign sel       = fn_code[SW-1:0];
  assign unused_fn = fn_code;

  always_comb begin
    alu_ctl = AC_ADD;
    if (aluop[1]) begin
      unique case (sel)
        FN_ADD:  alu_ctl = AC_ADD;
        FN_SUB:  alu_ctl = AC_SUB;
        FN_AND:  alu_ctl = AC_AND;
        FN_OR:   alu_ctl = AC_OR;
        FN_SLT:  alu_ctl = AC_SLT;
        default: alu_ctl = AC_ADD;
      endcase
    end else if (aluop[0]) begin
      alu_ctl = AC_SUB;
    end else begin
      alu_ctl = AC_ADD;
    end
  end
endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
  import ctl_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  output logic       dst_sel_rd,
  output logic       alu_b_imm,
  output logic       wb_from_mem,
  output logic       reg_we,
  output logic       mem_re,
  output logic       mem_we,
  output logic       br_en,
  output logic       jmp_en,
  output logic [3:0] alu_ctl
);
  ctl_t ctl;

  ctl_main_dec #(.OPW(OP_W)) i_main (
    .op_code (op_code),
    .ctl     (ctl)
  );

  ctl_alu_dec #(.FNW(FN_W), .ACW(AC_W)) i_alu (
    .aluop   (ctl.aluop),
    .fn_code (fn_code),
    .alu_ctl (alu_ctl)
  );

  assign dst_sel_rd  = ctl.dst_rd;
  assign alu_b_imm   = ctl.b_imm;
  assign wb_from_mem = ctl.wb_mem;
  assign reg_we      = ctl.reg_we;
  assign mem_re      = ctl.mem_re;
  assign mem_we      = ctl.mem_we;
  assign br_en       = ctl.br;
  assign jmp_en      = ctl.jmp;
endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
  input logic [5:0] op_code,
  input logic [5:0] fn_code,
  input logic       dst_sel_rd,
  input logic       alu_b_imm,
  input logic       wb_from_mem,
  input logic       reg_we,
  input logic       mem_re,
  input logic       mem_we,
  input logic       br_en,
  input logic       jmp_en,
  input logic [3:0] alu_ctl
);
  logic [11:0] unused_in;
  assign unused_in = {op_code, fn_code};

  always_comb begin
    a_r10_one_action: assert ($onehot0({mem_re, mem_we, br_en, jmp_en}))
      else $error("R10 more than one action request");
    a_r4_branch_sub: assert (!br_en || (alu_ctl == 4'b0110 && !reg_we && !alu_b_imm))
      else $error("R4 branch without subtract or with write");
    a_r3_store_quiet: assert (!mem_we || (!reg_we && alu_b_imm && alu_ctl == 4'b0010))
      else $error("R3 store decode inconsistent");
    a_r2_load_wb: assert (!mem_re || (reg_we && wb_from_mem && alu_b_imm && !dst_sel_rd))
      else $error("R2 load decode inconsistent");
    a_r5_jump_quiet: assert (!jmp_en || (!reg_we && !alu_b_imm && !wb_from_mem))
      else $error("R5 jump with side effects");
    a_r1_rd_dst: assert (!dst_sel_rd || (reg_we && !alu_b_imm && !wb_from_mem))
      else $error("R1 rd destination inconsistent");
  end
endmodule

bind ctl_decoder ctl_decoder_chk i_chk (.*);

// File: tb/test_ctl_decoder.sv
module test_ctl_decoder;
  logic       clk = 1'b0;
  logic [5:0] op_code;
  logic [5:0] fn_code;
  logic       dst_sel_rd, alu_b_imm, wb_from_mem, reg_we, mem_re, mem_we, br_en, jmp_en;
  logic [3:0] alu_ctl;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ctl_decoder i_ctl_decoder (.*);

  // {dst, bimm, wb, rwe, mre, mwe, br, j, alu[3:0]}
  function automatic logic [11:0] model(input logic [5:0] op, input logic [5:0] fn);
    logic [3:0] ac;
    case (fn[3:0])
      4'b0000: ac = 4'b0010;
      4'b0010: ac = 4'b0110;
      4'b0100: ac = 4'b0000;
      4'b0101: ac = 4'b0001;
      4'b1010: ac = 4'b0111;
      default: ac = 4'b0010;
    endcase
    case (op)
      6'd0:    return {8'b1001_0000, ac};
      6'd35:   return {8'b0111_1000, 4'b0010};
      6'd43:   return {8'b0100_0100, 4'b0010};
      6'd4:    return {8'b0000_0010, 4'b0110};
      6'd2:    return {8'b0000_0001, 4'b0010};
      default: return {8'b0000_0000, 4'b0010};
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] op);
    case (op)
      6'd0:    return "R1/R6/R7";
      6'd35:   return "R2/R8";
      6'd43:   return "R3/R8";
      6'd4:    return "R4/R8";
      6'd2:    return "R5/R8";
      default: return "R9/R8";
    endcase
  endfunction

  function automatic logic [11:0] got();
    return {dst_sel_rd, alu_b_imm, wb_from_mem, reg_we, mem_re, mem_we, br_en, jmp_en, alu_ctl};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input string tag);
    logic [11:0] exp_v;
    logic [11:0] act;
    @(posedge clk);
    #1;
    op_code = op;
    fn_code = fn;
    @(negedge clk);
    exp_v = model(op, fn);
    act   = got();
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d fn=%0d actual=%b expected=%b", tag, op, fn, act, exp_v);
    end
    n_run++;  // R10 check
    if ($countones({mem_re, mem_we, br_en, jmp_en}) > 1) begin
      n_fail++;
      $display("FAIL R10 op=%0d actual=%b expected=onehot0", op, {mem_re, mem_we, br_en, jmp_en});
    end
  endtask

  initial begin
    op_code = '0;
    fn_code = '0;
    void'($urandom(32'd20211));
    // starting state: all-zero word is register-format add
    apply(6'd0, 6'd32, "R1 start");
    // R6 each function code, both upper-bit variants (R7)
    apply(6'd0, 6'd32, "R6 add");
    apply(6'd0, 6'd34, "R6 sub");
    apply(6'd0, 6'd36, "R6 and");
    apply(6'd0, 6'd37, "R6 or");
    apply(6'd0, 6'd42, "R6 slt");
    apply(6'd0, 6'd10, "R7 slt upper 00");
    apply(6'd0, 6'd58, "R7 slt upper 11");
    apply(6'd0, 6'd21, "R7 or upper 01");
    apply(6'd0, 6'd39, "R6 other code");
    apply(6'd35, 6'd0,  "R2 load");
    apply(6'd43, 6'd34, "R3 store fn=sub");
    apply(6'd4,  6'd37, "R4 beq fn=or");
    apply(6'd2,  6'd42, "R5 jump fn=slt");
    apply(6'd63, 6'd0,  "R9 op 63");
    apply(6'd8,  6'd34, "R9 op 8");
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      logic [5:0] fn;
      int pick;
      pick = $urandom_range(0, 7);
      case (pick)
        0: op = 6'd0;
        1: op = 6'd35;
        2: op = 6'd43;
        3: op = 6'd4;
        4: op = 6'd2;
        default: op = 6'($urandom_range(0, 63));
      endcase
      fn = ($urandom_range(0, 1) == 1) ? {2'($urandom_range(0, 3)), 4'b1010} : 6'($urandom_range(0, 63));
      apply(op, fn, req_of(op));
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule